// File: doc/BRIEF.md
# GPIO Pad Controller with Receive Event Detection

This block controls one general-purpose I/O pad through a single 32-bit configuration word. The word sets the pad's direction with independent transmit and receive disables, holds the value driven onto the pad, and carries a 4-bit function selector. A selector of zero keeps the pad in GPIO mode. Any other value hands the pad to an alternate function, and the GPIO output enable is then released.

The receive path passes the pad input through a multi-flop synchronizer. An optional inversion is applied next, and then an event detector. The detector produces a continuous level, a one-cycle pulse on a single edge, a one-cycle pulse on either edge, or nothing, and this event goes to an interrupt collector. Falling-edge and active-low sensing come from combining the inversion bit with the edge and level codes. Four steering bits say which other interrupt destinations the event feeds. A write that puts the pad into GPIO mode clears these bits.

Software writes the whole word through a one-cycle write strobe and reads it back at any time. The read-back carries the synchronized input sample in a read-only bit. A separate output gives the pad value as a driver would read it.

Top module: `gpio_pad_evt`

## Requirements
- R1: After reset the configuration reads 0x0400_0100: GPIO mode (bits 13:10 = 0), transmitter disabled (bit 8 = 1), receiver enabled (bit 9 = 0), event selector bits 26:25 = 2 (off), steering bits 20:17 = 0, inversion bit 23 = 0, output value bit 0 = 0. The event output is low and pad_oe is low.
- R2: Only bits 0, 8, 9, 13:10, 20:17, 23 and 26:25 hold written values. All other bits read as zero, except bit 1, which ignores writes and always reads the synchronized pad input.
- R3: A change on pad_in reaches read-back bit 1 exactly two rising clock edges later.
- R4: When the selector is 0 (level), the event output continuously equals the synchronized input XOR the inversion bit, so setting bit 23 makes the event active-low.
- R5: When the selector is 1 (single edge), the event output is a one-cycle pulse when the synchronized input XOR the inversion bit goes from 0 to 1. This is a rising edge with bit 23 clear and a falling edge with bit 23 set.
- R6: When the selector is 3 (both edges), the event output is a one-cycle pulse on every change of the synchronized input.
- R7: The event output stays low while the selector is 2 or the receiver is disabled (bit 9 = 1), whatever pad_in does.
- R8: pad_out equals bit 0. pad_oe equals the inverse of bit 8 when bits 13:10 are zero, and is low for any nonzero function selector.
- R9: pad_val returns bit 0 when the transmitter is enabled (bit 8 = 0), and the synchronized input otherwise.
- R10: route_o shows bits 20:17. A write whose bits 13:10 are zero stores zero in bits 20:17, whatever was written there.
- R11: alt_mode_o shows the function selector, bits 13:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back, with the synchronized input in bit 1 |
| pad_in | input | 1 | Raw pad input level |
| pad_out | output | 1 | Value driven onto the pad |
| pad_oe | output | 1 | Pad output enable in GPIO mode |
| pad_val | output | 1 | Pad value as a driver reads it |
| evt_o | output | 1 | Receive event toward the interrupt collector |
| route_o | output | 4 | Event steering bits |
| alt_mode_o | output | 4 | Function selector |

## Verification
The detector is driven with isolated rising and falling steps and with up-and-down pulse pairs, under every selector code and both inversion settings. Pulse counts tell single-edge from both-edge detection, and the inversion bit tells rising from falling sensitivity. Level mode is held for several cycles, so a continuous level cannot pass for a pulse. Direction words move the pad between output, input and alternate-function settings, which separates the output-value and sampled-input read paths. Writes carrying steering bits with a zero and then a nonzero function selector confirm the clearing rule.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
    localparam int CFG_W      = 32;
    localparam int OUTV_BIT   = 0;
    localparam int INV_BIT_1  = 1;
    localparam int TXDIS_BIT  = 8;
    localparam int RXDIS_BIT  = 9;
    localparam int FSEL_LSB   = 10;
    localparam int FSEL_W     = 4;
    localparam int STEER_LSB  = 17;
    localparam int STEER_W    = 4;
    localparam int RXINV_BIT  = 23;
    localparam int EVSEL_LSB  = 25;
    localparam int EVSEL_W    = 2;

    typedef enum logic [EVSEL_W-1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } ev_sel_e;

    localparam logic [CFG_W-1:0] STORE_MASK =
        (CFG_W'(1) << OUTV_BIT) | (CFG_W'(1) << TXDIS_BIT) | (CFG_W'(1) << RXDIS_BIT) |
        (CFG_W'((1 << FSEL_W) - 1) << FSEL_LSB) |
        (CFG_W'((1 << STEER_W) - 1) << STEER_LSB) |
        (CFG_W'(1) << RXINV_BIT) |
        (CFG_W'((1 << EVSEL_W) - 1) << EVSEL_LSB);

    localparam logic [CFG_W-1:0] CFG_RESET =
        (CFG_W'(EV_OFF) << EVSEL_LSB) | (CFG_W'(1) << TXDIS_BIT);
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_evdet.sv
module gpio_pad_evdet
    import gpio_pad_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    smp_i,
    input  logic    inv_i,
    input  logic    rx_off_i,
    input  ev_sel_e sel_i,
    output logic    ev_o
);
    typedef struct packed {
        logic prev;
    } det_t;

    det_t st_d, st_q;
    logic cur_x, prev_x;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp_i;
        cur_x     = smp_i ^ inv_i;
        prev_x    = st_q.prev ^ inv_i;
        ev_o      = 1'b0;
        if (!rx_off_i) begin
            unique case (sel_i)
                EV_LEVEL: ev_o = cur_x;
                EV_EDGE:  ev_o = cur_x & ~prev_x;
                EV_BOTH:  ev_o = cur_x ^ prev_x;
                default:  ev_o = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpio_pad_evt.sv
module gpio_pad_evt
    import gpio_pad_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             pad_val,
    output logic             evt_o,
    output logic [3:0]       route_o,
    output logic [3:0]       alt_mode_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;
    logic             smp;
    logic             gpio_mode;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = cfg_wdata & STORE_MASK;
            if (cfg_d[FSEL_LSB +: FSEL_W] == '0)
                cfg_d[STEER_LSB +: STEER_W] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    gpio_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pad_in),
        .q_o  (smp)
    );

    gpio_pad_evdet u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_i   (smp),
        .inv_i   (cfg_q[RXINV_BIT]),
        .rx_off_i(cfg_q[RXDIS_BIT]),
        .sel_i   (ev_sel_e'(cfg_q[EVSEL_LSB +: EVSEL_W])),
        .ev_o    (evt_o)
    );

    always_comb begin
        gpio_mode            = (cfg_q[FSEL_LSB +: FSEL_W] == '0);
        cfg_rdata            = cfg_q;
        cfg_rdata[INV_BIT_1] = smp;
        pad_out              = cfg_q[OUTV_BIT];
        pad_oe               = gpio_mode & ~cfg_q[TXDIS_BIT];
        pad_val              = cfg_q[TXDIS_BIT] ? smp : cfg_q[OUTV_BIT];
        route_o              = cfg_q[STEER_LSB +: STEER_W];
        alt_mode_o           = cfg_q[FSEL_LSB +: FSEL_W];
    end
endmodule

// File: rtl/gpio_pad_evt_chk.sv
module gpio_pad_evt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        pad_oe,
    input logic        pad_val,
    input logic        evt_o,
    input logic [3:0]  route_o
);
    a_r7_event_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[9] || cfg_rdata[26:25] == 2'd2) |-> !evt_o);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && cfg_rdata[26:25] == 2'd1) |=>
        (!evt_o || cfg_rdata[26:25] != 2'd1 || !$stable(cfg_rdata[23])));

    a_r8_alt_releases_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[13:10] != 4'd0) |-> !pad_oe);

    a_r9_tx_readback: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[8] |-> (pad_val == cfg_rdata[0]));

    a_r10_gpio_no_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[13:10] == 4'd0) |-> (route_o == 4'd0));
endmodule

bind gpio_pad_evt gpio_pad_evt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_rdata(cfg_rdata),
    .pad_oe   (pad_oe),
    .pad_val  (pad_val),
    .evt_o    (evt_o),
    .route_o  (route_o)
);

// File: tb/gpio_pad_evt_tb.sv
`timescale 1ns/1ps
module gpio_pad_evt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_val, evt_o;
    logic [3:0]  route_o, alt_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_pad_evt u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_val(pad_val), .evt_o(evt_o),
        .route_o(route_o), .alt_mode_o(alt_mode_o)
    );

    // Reference model: stored word plus a history of sampled pad levels
    localparam logic [31:0] KEEP = 32'h069E_3F01;
    logic [31:0] m_cfg;
    bit          hist[$];   // hist[0] newest sample

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit smp_at(int k);
        return (hist.size() > k) ? hist[k] : 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 32'h0400_0100;
            hist.delete();
        end else begin
            hist.push_front(pad_in);
            if (hist.size() > 4) void'(hist.pop_back());
            if (cfg_we) begin
                m_cfg = cfg_wdata & KEEP;
                if (m_cfg[13:10] == 4'd0) m_cfg[20:17] = 4'd0;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit s, p, x, xp, ev;
            s  = smp_at(1);
            p  = smp_at(2);
            x  = s ^ m_cfg[23];
            xp = p ^ m_cfg[23];
            ev = 1'b0;
            if (!m_cfg[9]) begin
                case (m_cfg[26:25])
                    2'd0: ev = x;
                    2'd1: ev = x & ~xp;
                    2'd3: ev = x ^ xp;
                    default: ev = 1'b0;
                endcase
            end
            case (m_cfg[26:25])
                2'd0: check("R4 evt level", 32'(evt_o), 32'(ev));
                2'd1: check("R5 evt edge", 32'(evt_o), 32'(ev));
                2'd3: check("R6 evt both", 32'(evt_o), 32'(ev));
                default: check("R7 evt off", 32'(evt_o), 32'(ev));
            endcase
            check("R2 rdata", cfg_rdata, m_cfg | (32'(s) << 1));
            check("R8 pad_out", 32'(pad_out), 32'(m_cfg[0]));
            check("R8 pad_oe", 32'(pad_oe), 32'((m_cfg[13:10] == 4'd0) && !m_cfg[8]));
            check("R9 pad_val", 32'(pad_val), 32'(m_cfg[8] ? s : m_cfg[0]));
            check("R10 route", 32'(route_o), 32'(m_cfg[20:17]));
            check("R11 alt_mode", 32'(alt_mode_o), 32'(m_cfg[13:10]));
        end
    end

    task automatic wr(logic [31:0] v);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_pad(bit v);
        @(negedge clk); #1;
        pad_in = v;
    endtask

    task automatic count_ev(int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #2;
            if (evt_o) cnt++;
        end
    endtask

    function automatic logic [31:0] word(bit [1:0] ev, bit inv, bit rxd, bit txd, bit ov);
        return (32'(ev) << 25) | (32'(inv) << 23) | (32'(rxd) << 9) | (32'(txd) << 8) | 32'(ov);
    endfunction

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        check("R1 reset word", cfg_rdata, 32'h0400_0100);
        check("R1 reset evt", 32'(evt_o), 0);
        check("R1 reset oe", 32'(pad_oe), 0);

        // All ones: nonzero function selector keeps steering
        wr(32'hFFFF_FFFF);
        #1;
        check("R2 writable bits", cfg_rdata, 32'h069E_3F01);
        check("R11 alt mode", 32'(alt_mode_o), 32'hF);
        check("R8 oe released in alt mode", 32'(pad_oe), 0);
        check("R10 steering kept", 32'(route_o), 32'hF);

        // GPIO mode write clears steering
        wr(32'h001E_0000 | word(2'd2, 0, 0, 1, 0));
        #1;
        check("R10 steering cleared", 32'(route_o), 0);

        // Output direction, receiver off, edge selected
        wr(word(2'd1, 0, 1, 0, 1));
        #1;
        check("R8 oe driven", 32'(pad_oe), 1);
        check("R9 pad_val from output bit", 32'(pad_val), 1);
        set_pad(1); set_pad(0); set_pad(1);
        count_ev(5, cnt);
        check("R7 rx disabled no events", 32'(cnt), 0);
        set_pad(0);
        count_ev(4, cnt);

        // Input, level mode: synchronizer latency
        wr(word(2'd0, 0, 0, 1, 0));
        count_ev(3, cnt);
        set_pad(1);
        @(negedge clk); #2;
        check("R3 one edge: not yet", 32'(cfg_rdata[1]), 0);
        @(negedge clk); #2;
        check("R3 two edges: visible", 32'(cfg_rdata[1]), 1);
        check("R9 pad_val from input", 32'(pad_val), 1);
        count_ev(4, cnt);
        check("R4 level held", 32'(cnt), 4);
        wr(word(2'd0, 1, 0, 1, 0));
        count_ev(4, cnt);
        check("R4 active-low level", 32'(cnt), 0);

        // Single edge, rising
        wr(word(2'd1, 0, 0, 1, 0));
        set_pad(0);
        count_ev(4, cnt);
        set_pad(1);
        count_ev(5, cnt);
        check("R5 rising pulse", 32'(cnt), 1);
        set_pad(0);
        count_ev(5, cnt);
        check("R5 falling ignored", 32'(cnt), 0);

        // Single edge, inverted: falling
        wr(word(2'd1, 1, 0, 1, 0));
        set_pad(1);
        count_ev(5, cnt);
        check("R5 inverted rising ignored", 32'(cnt), 0);
        set_pad(0);
        count_ev(5, cnt);
        check("R5 inverted falling pulse", 32'(cnt), 1);

        // Both edges
        wr(word(2'd3, 0, 0, 1, 0));
        count_ev(3, cnt);
        set_pad(1);
        count_ev(4, cnt);
        set_pad(0);
        begin
            int c2;
            count_ev(5, c2);
            check("R6 both edges pulses", 32'(cnt + c2), 2);
        end

        // Events off
        wr(word(2'd2, 0, 0, 1, 0));
        set_pad(1); set_pad(0); set_pad(1);
        count_ev(5, cnt);
        check("R7 selector off", 32'(cnt), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule